// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store placed next to a direct-mapped first-level cache. It keeps lines that the main cache has recently pushed out. The requester consults it only after a main-cache miss; main-cache hits never reach it. Each lookup carries two things:

- a search key, formed from the main-cache set index joined with the tag of the wanted address;
- the line that the main cache is about to displace, with its own key, data and dirty flag.

On a match, the wanted line is returned and the displaced line takes its slot, so the two lines trade places. On no match, the displaced line is placed in a free slot if one exists, or otherwise in the least recently used slot. If that slot holds modified data, its contents first leave through a writeback port using a valid/ready handshake. The fill waits until the writeback has been accepted.

Recency is kept as one age value per slot, and the ages always form a permutation of 0..ENTRIES-1. A slot that is swapped or filled becomes age 0. Every slot that was younger than it moves one step older. The oldest slot has age ENTRIES-1.

Top module: `victim_buffer`

## Requirements
- R1: After reset every slot is empty, `req_ready` is 1, and `rsp_valid` and `wb_valid` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its key is compared with every valid slot at once. If no writeback is needed, `rsp_valid` is high for exactly one cycle, just after the accepting edge.
- R3: On a match, `rsp_hit` is 1 and `rsp_data`/`rsp_dirty` carry the matching slot's line. The displaced line, including its dirty flag, replaces that slot, so a later lookup with the displaced key hits and returns that data and dirty flag.
- R4: On a match while `vic_valid` is 0, the matching slot becomes empty, and a later lookup of that key misses.
- R5: On no match, `rsp_hit` is 0 and `rsp_dirty` is 0. If `vic_valid` is 1, the displaced line is stored.
- R6: While any slot is empty, a miss fills an empty slot and issues no writeback.
- R7: With all slots valid, a miss replaces the slot whose last fill or match is the oldest.
- R8: If the replaced slot is dirty, `wb_valid` rises one cycle after acceptance and carries that slot's key and data. The fill and the miss response (`rsp_valid` 1, `rsp_hit` 0) come only after the edge where `wb_ready` is 1.
- R9: If the replaced slot is clean, it is overwritten without a writeback.
- R10: While `wb_valid` is 1, `req_ready` is 0, and `wb_key`/`wb_data` hold steady until `wb_ready` is seen.
- R11: A miss with `vic_valid` 0 changes no slot and issues no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request after a main-cache miss |
| req_ready | output | 1 | Block can take a request |
| req_key | input | IDX_W+TAG_W | Search key {index, wanted tag} |
| vic_valid | input | 1 | Displaced main-cache line is valid |
| vic_key | input | IDX_W+TAG_W | Key {index, tag} of the displaced line |
| vic_data | input | DATA_W | Data of the displaced line |
| vic_dirty | input | 1 | Displaced line is modified |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup matched a slot |
| rsp_data | output | DATA_W | Line returned on a match |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| wb_valid | output | 1 | Writeback of an evicted dirty line pending |
| wb_ready | input | 1 | Memory side accepts the writeback |
| wb_key | output | IDX_W+TAG_W | Key of the line being written back |
| wb_data | output | DATA_W | Data of the line being written back |

## Verification
Two events can land on the same clock edge:

- a writeback of a dirty slot is accepted;
- that same slot is refilled with the displaced line.

The bench provokes this by running a four-slot configuration into full occupancy with mixed dirty flags, then holding `wb_ready` low for zero to two extra cycles before granting it. The outcome is judged in two ways. The writeback must show the evicted line's original key and data, not the incoming line. Later lookups of both keys must then match a model that applies the exchange only after the handshake.

// File: rtl/vb_pkg.sv
package vb_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WB   = 1'b1
  } vb_state_e;

endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int N     = 64,
  parameter int KEY_W = 28,
  parameter int AW    = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0][KEY_W-1:0] keys,
  input  logic [N-1:0]            valids,
  input  logic [N-1:0][AW-1:0]    ages,
  input  logic [KEY_W-1:0]        search_key,
  output logic                    hit,
  output logic [AW-1:0]           hit_idx,
  output logic                    free_any,
  output logic [AW-1:0]           free_idx,
  output logic [AW-1:0]           lru_idx
);

  localparam logic [AW-1:0] OLDEST = AW'(N - 1);

  logic [N-1:0] hit_vec;
  logic [N-1:0] old_vec;

  // parallel compare against every slot
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valids[g] && (keys[g] == search_key);
    assign old_vec[g] = (ages[g] == OLDEST);
  end

  assign hit      = |hit_vec;
  assign free_any = ~&valids;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = AW'(i);
    end
  end

  // lowest-numbered empty slot
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valids[i]) free_idx = AW'(i);
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (old_vec[i]) lru_idx = AW'(i);
    end
  end

  // R2: keys are unique, so at most one slot can match
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1);

  // R7: exactly one slot carries the oldest age
  a_r7_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(old_vec) == 1);

endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int N  = 64,
  parameter int AW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch_en,
  input  logic [AW-1:0]        touch_idx,
  output logic [N-1:0][AW-1:0] ages
);

  logic [N-1:0][AW-1:0] age_q;
  logic [N-1:0][AW-1:0] age_d;
  logic [AW-1:0]        touched_age;
  logic [N-1:0]         mru_vec;

  assign touched_age = age_q[touch_idx];

  for (genvar g = 0; g < N; g++) begin : g_age
    always_comb begin
      age_d[g] = age_q[g];
      if (touch_en) begin
        if (touch_idx == AW'(g)) begin
          age_d[g] = '0;
        end else if (age_q[g] < touched_age) begin
          age_d[g] = age_q[g] + 1'b1;
        end
      end
    end
    assign mru_vec[g] = (age_q[g] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  assign ages = age_q;

  // R7: ages stay a permutation, so exactly one slot is youngest
  a_r7_one_youngest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mru_vec) == 1);

  // R7: the slot just used becomes youngest
  a_r7_touch_young: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_idx)] == '0);

endmodule

// File: rtl/vb_ctrl.sv
module vb_ctrl
  import vb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  input  logic vic_valid,
  input  logic slot_dirty,
  input  logic wb_ready,
  output logic req_ready,
  output logic accept,
  output logic take_pend,
  output logic fill_now,
  output logic fill_pend,
  output logic rsp_fire,
  output logic wb_valid
);

  vb_state_e state_q;
  vb_state_e state_d;
  logic      need_wb;

  assign need_wb   = !hit && vic_valid && slot_dirty;
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign take_pend = accept && need_wb;
  assign fill_now  = accept && !hit && vic_valid && !need_wb;
  assign fill_pend = (state_q == ST_WB) && wb_ready;
  assign rsp_fire  = (accept && !need_wb) || fill_pend;
  assign wb_valid  = (state_q == ST_WB);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (take_pend) state_d = ST_WB;
      ST_WB:   if (wb_ready)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8: a writeback only starts from an accepted miss onto a dirty slot
  a_r8_wb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(req_valid && need_wb));

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 9,
  parameter int TAG_W   = 19,
  parameter int DATA_W  = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IDX_W+TAG_W-1:0] req_key,
  input  logic                   vic_valid,
  input  logic [IDX_W+TAG_W-1:0] vic_key,
  input  logic [DATA_W-1:0]      vic_data,
  input  logic                   vic_dirty,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [DATA_W-1:0]      rsp_data,
  output logic                   rsp_dirty,
  output logic                   wb_valid,
  input  logic                   wb_ready,
  output logic [IDX_W+TAG_W-1:0] wb_key,
  output logic [DATA_W-1:0]      wb_data
);

  localparam int KEY_W = IDX_W + TAG_W;
  localparam int AW    = $clog2(ENTRIES);

  // slot storage
  logic [ENTRIES-1:0][KEY_W-1:0]  key_q,   key_d;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q,  data_d;
  logic [ENTRIES-1:0]             dirty_q, dirty_d;
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][AW-1:0]     ages;

  // lookup results
  logic          hit;
  logic [AW-1:0] hit_idx;
  logic          free_any;
  logic [AW-1:0] free_idx;
  logic [AW-1:0] lru_idx;
  logic [AW-1:0] fill_idx;
  logic          slot_dirty;

  // control
  logic accept, take_pend, fill_now, fill_pend, rsp_fire;

  // held line while a writeback is outstanding
  logic [AW-1:0]     pend_slot;
  logic [KEY_W-1:0]  pend_key;
  logic [DATA_W-1:0] pend_data;
  logic              pend_dirty;

  // single write port into the slot array
  logic              wr_en;
  logic [AW-1:0]     wr_idx;
  logic [KEY_W-1:0]  wr_key;
  logic [DATA_W-1:0] wr_data;
  logic              wr_dirty;
  logic              wr_valid;

  // response registers
  logic              rsp_valid_q, rsp_hit_q, rsp_dirty_q;
  logic [DATA_W-1:0] rsp_data_q;

  vb_match #(.N(ENTRIES), .KEY_W(KEY_W), .AW(AW)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .keys      (key_q),
    .valids    (valid_q),
    .ages      (ages),
    .search_key(req_key),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .free_any  (free_any),
    .free_idx  (free_idx),
    .lru_idx   (lru_idx)
  );

  assign fill_idx   = free_any ? free_idx : lru_idx;
  assign slot_dirty = valid_q[fill_idx] && dirty_q[fill_idx];

  vb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hit       (hit),
    .vic_valid (vic_valid),
    .slot_dirty(slot_dirty),
    .wb_ready  (wb_ready),
    .req_ready (req_ready),
    .accept    (accept),
    .take_pend (take_pend),
    .fill_now  (fill_now),
    .fill_pend (fill_pend),
    .rsp_fire  (rsp_fire),
    .wb_valid  (wb_valid)
  );

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = hit_idx;
    wr_key   = vic_key;
    wr_data  = vic_data;
    wr_dirty = vic_dirty;
    wr_valid = vic_valid;
    if (fill_pend) begin
      wr_en    = 1'b1;
      wr_idx   = pend_slot;
      wr_key   = pend_key;
      wr_data  = pend_data;
      wr_dirty = pend_dirty;
      wr_valid = 1'b1;
    end else if (accept && hit) begin
      wr_en    = 1'b1;
      wr_idx   = hit_idx;
    end else if (fill_now) begin
      wr_en    = 1'b1;
      wr_idx   = fill_idx;
    end
  end

  vb_age #(.N(ENTRIES), .AW(AW)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch_en (wr_en && wr_valid),
    .touch_idx(wr_idx),
    .ages     (ages)
  );

  always_comb begin
    key_d   = key_q;
    data_d  = data_q;
    dirty_d = dirty_q;
    valid_d = valid_q;
    if (wr_en) begin
      key_d[wr_idx]   = wr_key;
      data_d[wr_idx]  = wr_data;
      dirty_d[wr_idx] = wr_dirty && wr_valid;
      valid_d[wr_idx] = wr_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q  <= key_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_pend) begin
      pend_slot  <= fill_idx;
      pend_key   <= vic_key;
      pend_data  <= vic_data;
      pend_dirty <= vic_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_dirty_q <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_fire;
      if (rsp_fire) begin
        rsp_hit_q   <= accept && hit;
        rsp_dirty_q <= accept && hit && dirty_q[hit_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_fire) begin
      rsp_data_q <= (accept && hit) ? data_q[hit_idx] : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_dirty = rsp_dirty_q;
  assign wb_key    = key_q[pend_slot];
  assign wb_data   = data_q[pend_slot];

  // R8: a granted writeback is followed by the miss response
  a_r8_rsp_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> rsp_valid && !rsp_hit);

  // R10: writeback contents hold while not accepted
  a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_key) && $stable(wb_data));

  // R10: no new lookup while a writeback is open
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !req_ready);

  // R2: each response follows an acceptance or a granted writeback
  a_r2_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready) || $past(wb_valid && wb_ready));

  // R5: a miss response never reports modified data
  a_r5_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_dirty);

endmodule

// File: tb/victim_buffer_bench.sv
module victim_buffer_bench;

  localparam int N  = 4;
  localparam int IW = 2;
  localparam int TW = 2;
  localparam int KW = IW + TW;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready;
  logic [KW-1:0] req_key;
  logic          vic_valid, vic_dirty;
  logic [KW-1:0] vic_key;
  logic [DW-1:0] vic_data;
  logic          rsp_valid, rsp_hit, rsp_dirty;
  logic [DW-1:0] rsp_data;
  logic          wb_valid, wb_ready;
  logic [KW-1:0] wb_key;
  logic [DW-1:0] wb_data;

  int checks = 0;
  int errors = 0;

  // reference model of the slots
  logic [KW-1:0] mk [N];
  logic [DW-1:0] md [N];
  bit            mdy[N];
  bit            mv [N];
  int            mage[N];
  logic [31:0]   rs = 32'h1234_5678;

  always #5 clk = ~clk;

  victim_buffer #(.ENTRIES(N), .IDX_W(IW), .TAG_W(TW), .DATA_W(DW)) u_victim_buffer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key),
    .vic_valid(vic_valid), .vic_key(vic_key), .vic_data(vic_data), .vic_dirty(vic_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_key(wb_key), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic int find(input logic [KW-1:0] k);
    for (int i = 0; i < N; i++) if (mv[i] && mk[i] == k) return i;
    return -1;
  endfunction

  function automatic int pick();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    for (int i = 0; i < N; i++) if (mage[i] == N - 1) return i;
    return 0;
  endfunction

  function automatic void touch(input int s);
    for (int j = 0; j < N; j++) if (mage[j] < mage[s]) mage[j]++;
    mage[s] = 0;
  endfunction

  task automatic do_op(input logic [KW-1:0] key, input bit vv, input logic [KW-1:0] vk,
                       input logic [DW-1:0] vd, input bit vdy, input int delay);
    int  h, s;
    bit  wb, full;
    logic [KW-1:0] ek;
    logic [DW-1:0] ed;
    h    = find(key);
    s    = pick();
    full = mv[s];
    wb   = (h < 0) && vv && mv[s] && mdy[s];
    chk("R10 ready before request", req_ready, 1);
    req_valid = 1'b1; req_key = key;
    vic_valid = vv; vic_key = vk; vic_data = vd; vic_dirty = vdy;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (wb) begin
      ek = mk[s]; ed = md[s];
      chk("R8 wb_valid raised", wb_valid, 1);
      chk("R7 evicted oldest key", wb_key, ek);
      chk("R8 wb_data", wb_data, ed);
      chk("R10 req_ready low", req_ready, 0);
      chk("R8 rsp waits for wb", rsp_valid, 0);
      for (int d = 0; d < delay; d++) begin
        @(posedge clk); #1;
        chk("R10 wb_valid held", wb_valid, 1);
        chk("R10 wb_key stable", wb_key, ek);
        chk("R10 wb_data stable", wb_data, ed);
        chk("R8 rsp still waits", rsp_valid, 0);
      end
      wb_ready = 1'b1;
      @(posedge clk); #1;
      wb_ready = 1'b0;
      chk("R8 wb_valid dropped", wb_valid, 0);
    end else begin
      if (!vv)        chk("R11 no writeback", wb_valid, 0);
      else if (h >= 0) chk("R3 no writeback on swap", wb_valid, 0);
      else if (full)  chk("R9 clean replace no writeback", wb_valid, 0);
      else            chk("R6 empty fill no writeback", wb_valid, 0);
    end
    chk("R2 rsp_valid", rsp_valid, 1);
    if (h >= 0) begin
      chk(vv ? "R3 rsp_hit" : "R4 rsp_hit", rsp_hit, 1);
      chk("R3 rsp_data", rsp_data, md[h]);
      chk("R3 rsp_dirty", rsp_dirty, mdy[h]);
      if (vv) begin
        mk[h] = vk; md[h] = vd; mdy[h] = vdy; touch(h);
      end else begin
        mv[h] = 0;
      end
    end else begin
      chk(full ? "R7 rsp_hit miss" : "R5 rsp_hit miss", rsp_hit, 0);
      chk("R5 rsp_dirty miss", rsp_dirty, 0);
      if (vv) begin
        mk[s] = vk; md[s] = vd; mdy[s] = vdy; mv[s] = 1; touch(s);
      end
    end
    @(posedge clk); #1;
    chk("R2 rsp one cycle", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [KW-1:0] k, vk;
    rst_n = 1'b0; req_valid = 1'b0; req_key = '0; vic_valid = 1'b0;
    vic_key = '0; vic_data = '0; vic_dirty = 1'b0; wb_ready = 1'b0;
    for (int i = 0; i < N; i++) begin
      mk[i] = '0; md[i] = '0; mdy[i] = 0; mv[i] = 0; mage[i] = i;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 req_ready in reset", req_ready, 1);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    chk("R1 wb_valid in reset", wb_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 wb_valid after reset", wb_valid, 0);
    // R1: every key misses on an empty buffer
    for (int i = 0; i < 16; i++) do_op(KW'(i), 1'b0, '0, '0, 1'b0, 0);

    // directed: fill, swap, invalidate, refill, dirty eviction, no-op miss
    for (int i = 1; i <= 4; i++) do_op(4'd9, 1'b1, KW'(i), DW'(8'h10 + i), i[0], 0);
    do_op(4'd2, 1'b1, 4'd5, 8'h55, 1'b0, 0);   // R3
    do_op(4'd5, 1'b0, 4'd0, 8'h00, 1'b0, 0);   // R4
    do_op(4'd5, 1'b0, 4'd0, 8'h00, 1'b0, 0);   // R4 gone
    do_op(4'd10, 1'b1, 4'd6, 8'h66, 1'b1, 0);  // R6
    do_op(4'd11, 1'b1, 4'd7, 8'h77, 1'b0, 3);  // R8, key 1 oldest and dirty
    do_op(4'd12, 1'b0, 4'd0, 8'h00, 1'b0, 0);  // R11
    do_op(4'd1, 1'b0, 4'd0, 8'h00, 1'b0, 0);   // R7 key 1 left

    // near-exhaustive sweep over the 16-key space
    for (int n = 0; n < 3000; n++) begin
      k  = KW'(rnd() % 16);
      vk = KW'(rnd() % 16);
      while (vk == k || find(vk) >= 0) vk = vk + 1'b1;
      do_op(k, (rnd() % 8) != 0, vk, DW'(rnd()), rnd() % 2 == 1, int'(rnd() % 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule